// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a half-duplex synchronous serial link on which it acts as master. It generates the shift clock itself from a programmable divider and samples the serial data line. Each completed word is 8 bits, or 9 bits when the ninth-bit option is on. The word moves from the shift register into a two-entry receive FIFO. The host sees the FIFO head through a data port, a ninth-bit status bit, a ready flag and an overrun flag. It advances the FIFO with a one-cycle read strobe.

The host starts reception by writing a small control register. It can select a single word, which clears its own request afterwards, or continuous reception, which runs until the host clears it. When the FIFO is already full, a further completed word raises a sticky overrun flag. From then on, no word reaches the FIFO until the continuous request is written to zero.

Top module: `sync_master_rx`

## Requirements
- R1: With reception active, the shift clock `sclk_o` has a period of 2*(`div_val`+1) system clocks and starts low. With no reception requested, `sclk_o` is held low.
- R2: Each data bit is taken from `sdata_i` at the falling edge of `sclk_o`, least significant bit first. The received byte appears on `rx_data`.
- R3: When the nine-bit control bit (bit 2) is set, a word has 9 bits and the last one received is stored per FIFO entry and shown on `rx_bit9` for the head entry. In 8-bit mode, `rx_bit9` reads 0 for that entry.
- R4: Control bit 0 (single) with bit 1 clear receives exactly one word. Bit 0 then clears itself in `ctrl_rdata`, and `sclk_o` stays low afterwards.
- R5: Control bit 1 (continuous) receives word after word until it is written to 0. When bits 0 and 1 are both set, continuous behaviour governs and bit 0 is not cleared.
- R6: The FIFO holds two words and returns them in arrival order. `rx_ready` is high exactly while the FIFO holds at least one word. A pulse on `data_rd` removes the head entry.
- R7: A word that completes while the FIFO is full sets `rx_overrun` and is discarded. While `rx_overrun` is set, every completed word is discarded.
- R8: A control write with bit 1 equal to 0 clears `rx_overrun`. Words already held in the FIFO are kept.
- R9: `rx_irq` equals `rx_ready` AND control bit 3 (interrupt enable).
- R10: A `data_rd` pulse while the FIFO is empty has no effect: `rx_ready` stays low and the next word is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: bit0 single, bit1 continuous, bit2 nine-bit, bit3 interrupt enable |
| div_val | input | DIV_W | Shift clock divider value |
| data_rd | input | 1 | Data read strobe, pops the FIFO head |
| sdata_i | input | 1 | Serial receive data |
| ctrl_rdata | output | 4 | Current control register |
| sclk_o | output | 1 | Generated shift clock |
| rx_ready | output | 1 | FIFO holds at least one word |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_bit9 | output | 1 | Ninth bit of the FIFO head |
| rx_data | output | 8 | Data byte of the FIFO head |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a third and a fourth word completing in continuous mode while the host has not read anything. The third word must then set the overrun flag and the fourth must be dropped silently. Reaching it needs uninterrupted bit-accurate driving of the data line across word boundaries. The bench does this by following each rising shift-clock edge and presenting the next bit before the falling edge. Random iterations choose the divider, the word width and a run of one to four words, and a few directed runs force the full-FIFO overrun and its clearing.

// File: rtl/smr_pkg.sv
package smr_pkg;
    localparam int SMR_DATA_W = 8;
    localparam int SMR_CTRL_W = 4;

    typedef struct packed {
        logic                  b9;
        logic [SMR_DATA_W-1:0] data;
    } smr_word_t;

    typedef struct packed {
        logic ie;
        logic nine;
        logic cont;
        logic single;
    } smr_ctrl_t;
endpackage

// File: rtl/smr_clkgen.sv
module smr_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } cg_state_t;

    cg_state_t q, d;

    always_comb begin
        d      = q;
        fall_o = 1'b0;
        if (!run_i) begin
            d.cnt  = '0;
            d.sclk = 1'b0;
        end else if (q.cnt >= div_i) begin
            d.cnt  = '0;
            d.sclk = !q.sclk;
            fall_o = q.sclk;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o = q.sclk;

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_o); // R1
endmodule

// File: rtl/smr_shifter.sv
module smr_shifter
    import smr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      nine_i,
    input  logic      fall_i,
    input  logic      sdata_i,
    output logic      done_o,
    output smr_word_t word_o
);
    localparam int SH_W  = SMR_DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
    } sh_state_t;

    sh_state_t q, d;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        d        = q;
        done_o   = 1'b0;
        last_idx = nine_i ? CNT_W'(SH_W - 1) : CNT_W'(SMR_DATA_W - 1);
        word_o   = '0;
        if (!run_i) begin
            d.cnt = '0;
        end else if (fall_i) begin
            d.sh = {sdata_i, q.sh[SH_W-1:1]};
            if (q.cnt >= last_idx) begin
                d.cnt  = '0;
                done_o = 1'b1;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
        if (nine_i) begin
            word_o.b9   = d.sh[SH_W-1];
            word_o.data = d.sh[SMR_DATA_W-1:0];
        end else begin
            word_o.b9   = 1'b0;
            word_o.data = d.sh[SH_W-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fall_i && run_i)); // R2
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(SH_W)); // R3
endmodule

// File: rtl/smr_fifo.sv
module smr_fifo
    import smr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  smr_word_t wdata_i,
    input  logic      pop_i,
    output smr_word_t head_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        smr_word_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } ff_state_t;

    ff_state_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d       = q;
        empty_o = (q.cnt == '0);
        full_o  = (q.cnt == CW'(DEPTH));
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        head_o  = q.mem[q.rp];
        if (do_push) begin
            d.mem[q.wp] = wdata_i;
            d.wp        = nxt(q.wp);
        end
        if (do_pop) d.rp = nxt(q.rp);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)); // R6
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R7
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o); // R10
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [SMR_CTRL_W-1:0] ctrl_wdata,
    input  logic [DIV_W-1:0]      div_val,
    input  logic                  data_rd,
    input  logic                  sdata_i,
    output logic [SMR_CTRL_W-1:0] ctrl_rdata,
    output logic                  sclk_o,
    output logic                  rx_ready,
    output logic                  rx_overrun,
    output logic                  rx_bit9,
    output logic [SMR_DATA_W-1:0] rx_data,
    output logic                  rx_irq
);
    typedef struct packed {
        smr_ctrl_t ctrl;
        logic      ovr;
    } top_state_t;

    top_state_t q, d;
    smr_ctrl_t  wr_ctrl;
    logic       run, fall, done, push, full, empty;
    smr_word_t  sh_word, head;

    assign wr_ctrl = smr_ctrl_t'(ctrl_wdata);
    assign run     = q.ctrl.cont || q.ctrl.single;

    smr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_val),
        .sclk_o (sclk_o),
        .fall_o (fall)
    );

    smr_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .nine_i  (q.ctrl.nine),
        .fall_i  (fall),
        .sdata_i (sdata_i),
        .done_o  (done),
        .word_o  (sh_word)
    );

    smr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (sh_word),
        .pop_i   (data_rd),
        .head_o  (head),
        .empty_o (empty),
        .full_o  (full)
    );

    always_comb begin
        d    = q;
        push = done && !q.ovr && !full;
        if (ctrl_we) begin
            d.ctrl = wr_ctrl;
            if (!wr_ctrl.cont) d.ovr = 1'b0;
        end else begin
            if (done && full) d.ovr = 1'b1;
            if (done && q.ctrl.single && !q.ctrl.cont) d.ctrl.single = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_rdata = q.ctrl;
    assign rx_overrun = q.ovr;
    assign rx_ready   = !empty;
    assign rx_data    = head.data;
    assign rx_bit9    = head.b9;
    assign rx_irq     = rx_ready && q.ctrl.ie;

    AST_OVR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> !push); // R7
    AST_SINGLE_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.ctrl.single && !q.ctrl.cont && !ctrl_we) |=> !ctrl_rdata[0]); // R4
    AST_CONT_KEEPS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.single && q.ctrl.cont && !ctrl_we) |=> ctrl_rdata[0]); // R5
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_wdata[1]) |=> !rx_overrun); // R8
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_ready); // R9
endmodule

// File: tb/sync_master_rx_test.sv
`timescale 1ns/1ps
module sync_master_rx_test;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_we = 1'b0;
    logic [3:0]       ctrl_wdata = '0;
    logic [DIV_W-1:0] div_val = '0;
    logic             data_rd = 1'b0;
    logic             sdata_i = 1'b0;
    logic [3:0]       ctrl_rdata;
    logic             sclk_o, rx_ready, rx_overrun, rx_bit9, rx_irq;
    logic [7:0]       rx_data;

    int checks = 0;
    int errors = 0;
    logic [8:0] mq[$];
    bit movr = 0;
    bit mie  = 0;

    always #2.5 clk = ~clk;

    sync_master_rx #(.DIV_W(DIV_W), .FIFO_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .div_val(div_val), .data_rd(data_rd), .sdata_i(sdata_i),
        .ctrl_rdata(ctrl_rdata), .sclk_o(sclk_o), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_bit9(rx_bit9), .rx_data(rx_data), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [3:0] v, input int dv);
        @(negedge clk);
        div_val    = DIV_W'(dv);
        ctrl_wdata = v;
        ctrl_we    = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        mie = v[3];
        if (!v[1]) movr = 0;
    endtask

    task automatic send_word(input logic [8:0] w, input bit nine);
        int nb = nine ? 9 : 8;
        for (int i = 0; i < nb; i++) begin
            @(posedge sclk_o);
            #1 sdata_i = w[i];
        end
        @(negedge sclk_o);
        #1;
        if (movr) begin
        end else if (mq.size() == 2) begin
            movr = 1;
        end else begin
            mq.push_back(nine ? w : {1'b0, w[7:0]});
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "ready", rx_ready, mq.size() != 0);
        chk(req, "overrun", rx_overrun, movr);
        chk("R9", "irq", rx_irq, (mq.size() != 0) && mie);
        if (mq.size() != 0) begin
            chk(req, "data", rx_data, mq[0][7:0]);
            chk("R3", "bit9", rx_bit9, mq[0][8]);
        end
    endtask

    task automatic pop_one();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
        #1;
    endtask

    task automatic drain(input string req);
        while (mq.size() != 0) begin
            check_state(req);
            pop_one();
        end
        check_state(req);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        realtime t1, t2;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1", "reset sclk", sclk_o, 0);
        chk("R6", "reset ready", rx_ready, 0);
        chk("R7", "reset overrun", rx_overrun, 0);
        chk("R9", "reset irq", rx_irq, 0);
        chk("R4", "reset ctrl", ctrl_rdata, 0);

        // R1 period with divider 3: expect 8 system clocks
        wr_ctrl(4'b0010, 3);
        @(posedge sclk_o); t1 = $realtime;
        @(posedge sclk_o); t2 = $realtime;
        chk("R1", "sclk period", int'((t2 - t1) / 5.0), 8);
        wr_ctrl(4'b0000, 3);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R1", "idle low", sclk_o, 0);
        end

        // R10 pop on empty FIFO
        pop_one();
        chk("R10", "empty pop ready", rx_ready, 0);

        // R4 single word, 9-bit, with interrupt
        wr_ctrl(4'b1101, 1);
        send_word(9'h1A5, 1);
        check_state("R4");
        chk("R4", "single cleared", ctrl_rdata, 4'b1100);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R4", "sclk stays low", sclk_o, 0);
        end
        drain("R4");

        // R5 priority: single+continuous receives two words, single stays set
        wr_ctrl(4'b0011, 0);
        send_word(9'h03C, 0);
        check_state("R5");
        send_word(9'h0C3, 0);
        check_state("R5");
        chk("R5", "single kept", ctrl_rdata, 4'b0011);
        wr_ctrl(4'b0000, 0);
        drain("R5");

        // R7/R8 directed overrun: four words, third sets overrun, fourth dropped
        wr_ctrl(4'b1010, 2);
        send_word(9'h011, 0);
        send_word(9'h022, 0);
        send_word(9'h033, 0);
        check_state("R7");
        send_word(9'h044, 0);
        check_state("R7");
        wr_ctrl(4'b1000, 2);
        chk("R8", "overrun cleared", rx_overrun, 0);
        chk("R8", "fifo kept", rx_ready, 1);
        drain("R8");

        // random runs
        for (int it = 0; it < 30; it++) begin
            bit nine = 1'($urandom % 2);
            bit ie   = 1'($urandom % 2);
            int dv   = int'($urandom % 4);
            int k    = 1 + int'($urandom % 4);
            wr_ctrl({ie, nine, 1'b1, 1'b0}, dv);
            for (int j = 0; j < k; j++) begin
                send_word(9'($urandom), nine);
                check_state(j >= 2 ? "R7" : "R2");
            end
            wr_ctrl({ie, nine, 1'b0, 1'b0}, dv);
            repeat (3) @(negedge clk);
            chk("R1", "idle after clear", sclk_o, 0);
            chk("R8", "overrun after clear", rx_overrun, 0);
            drain("R6");
            pop_one();
            chk("R10", "empty pop", rx_ready, 0);
        end

        finish_run();
    end
endmodule